// File: doc/BRIEF.md
# Key Wrap Round Sequencer

This block runs the iterative passes of 64-bit-block key wrapping and unwrapping over an object of up to 512 blocks. The blocks live in a block memory beside the sequencer. The sequencer reaches them through a read/write port with a one-cycle read latency. It holds the 64-bit integrity value A itself. Software loads the starting A, writes the blocks into memory and pulses `start`, together with the block count, the mode, the key and the key-length select.

Each step reads one block and presents a 128-bit word to an external block-cipher engine through a start/ready handshake. It then folds the engine's answer back into A and the block. A running step counter t supplies the value that the step mixes into A. In wrap mode t counts up from 1; in unwrap mode it counts down from 6n. No multiplier is needed. After the last step the block raises `done`. The final A and the rewritten blocks can then be read out.

The block does not compute the starting integrity value, pad the message or check the unwrapped result. The cipher datapath lives outside the block.

Top module: `kw_round_seq`

## Requirements
- R1: Wrap mode runs passes j = 0..5 in order. In each pass it runs i = 1..n in order. Each step sends exactly one request with `cph_decrypt`=0 and `cph_din` = {A, R[i]}, A in bits 127:64. A run makes exactly 6n requests.
- R2: After a wrap step, A becomes `cph_dout[127:64]` XOR t, where t = n*j + i is zero-extended to 64 bits. R[i] is overwritten with `cph_dout[63:0]`.
- R3: Unwrap mode runs j = 5..0 and i = n..1. Each step sends `cph_decrypt`=1 and `cph_din` = {A XOR t, R[i]}. Afterwards A takes `cph_dout[127:64]` and R[i] takes `cph_dout[63:0]`. An unwrap under the same key undoes a wrap.
- R4: `key` and `key_wide` are captured on an accepted start and presented unchanged on `cph_key` and `cph_key_wide` for the whole run. `key_wide`=1 selects a 256-bit key. `key_wide`=0 selects a 128-bit key held in `key[127:0]`.
- R5: `cph_start` is a one-cycle pulse. No further pulse comes until `cph_ready` has answered it, so at most one request is outstanding.
- R6: A start is ignored when `blk_cnt` is 0 or above 512. `busy` stays low, and `done` and A keep their values.
- R7: A start while `busy` is high is ignored. This includes the cycle of the final `cph_ready`. The running job's count, mode and key do not change.
- R8: `done` rises in the cycle after the last write-back and stays high. It clears in the cycle after the next accepted start. `done` and `busy` are never high together.
- R9: While the block is idle, `a_load` writes `a_load_val` into A, which is visible on `a_val` in the next cycle. While the block is busy, `a_load` is ignored.
- R10: After reset, `busy`, `done`, `cph_start`, `mem_rd` and `mem_we` are all low.
- R11: Block R[i] sits at memory address i-1. A step first reads that address, with data arriving one cycle after `mem_rd`. The write-back to the same address happens in the cycle `cph_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse for a run |
| unwrap | input | 1 | 1 = unwrap, 0 = wrap |
| blk_cnt | input | 10 | Number of 64-bit blocks n, excluding A |
| key | input | 256 | Cipher key |
| key_wide | input | 1 | 1 = 256-bit key, 0 = 128-bit key |
| a_load | input | 1 | Load A from a_load_val when idle |
| a_load_val | input | 64 | Starting integrity value |
| a_val | output | 64 | Current integrity value A |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished |
| mem_rd | output | 1 | Block memory read enable |
| mem_we | output | 1 | Block memory write enable |
| mem_addr | output | 9 | Block memory address (i-1) |
| mem_wdata | output | 64 | Block memory write data |
| mem_rdata | input | 64 | Block memory read data, one cycle after mem_rd |
| cph_start | output | 1 | Cipher request pulse |
| cph_decrypt | output | 1 | Cipher direction, 1 = decrypt |
| cph_key_wide | output | 1 | Cipher key length select |
| cph_key | output | 256 | Cipher key |
| cph_din | output | 128 | Cipher input word |
| cph_ready | input | 1 | Cipher result valid pulse |
| cph_dout | input | 128 | Cipher result word |

## Verification
The final cipher answer closes the job and raises `done`. A fresh start pulse can arrive in that same cycle, while `busy` is still high. The bench's cipher stand-in drives `start` high exactly on the cycle it returns the 6n-th `cph_ready`. It also pulses `start` and `a_load` with different values in the middle of another run. In both cases the final A and every block must match the bench's own model of the original job. `done` must be high and `busy` low after the last step, and no second run may begin.

// File: rtl/kw_pkg.sv
package kw_pkg;
  localparam int KW_PASSES = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_LAT,
    ST_REQ,
    ST_WAIT
  } kw_state_e;
endpackage

// File: rtl/kw_step_ctr.sv
module kw_step_ctr #(
  parameter int CNT_W = 10,
  parameter int T_W   = 12,
  parameter int J_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             adv,
  input  logic             init_uw,
  input  logic             run_uw,
  input  logic [CNT_W-1:0] n_init,
  input  logic [CNT_W-1:0] n_lim,
  output logic [CNT_W-1:0] i_q,
  output logic [J_W-1:0]   j_q,
  output logic [T_W-1:0]   t_q,
  output logic             last
);
  import kw_pkg::*;

  localparam logic [J_W-1:0]   J_TOP = J_W'(KW_PASSES - 1);
  localparam logic [CNT_W-1:0] I_ONE = CNT_W'(1);

  logic [CNT_W-1:0] i_d;
  logic [J_W-1:0]   j_d;
  logic [T_W-1:0]   t_d;
  logic [T_W-1:0]   n_ext;
  logic [T_W-1:0]   six_n;
  logic             ctr_en;

  assign n_ext  = T_W'(n_init);
  assign six_n  = (n_ext << 2) + (n_ext << 1);
  assign ctr_en = init | adv;

  assign last = run_uw ? ((j_q == '0) && (i_q == I_ONE))
                       : ((j_q == J_TOP) && (i_q == n_lim));

  always_comb begin
    i_d = i_q;
    j_d = j_q;
    t_d = t_q;
    if (init) begin
      if (init_uw) begin
        i_d = n_init;
        j_d = J_TOP;
        t_d = six_n;
      end else begin
        i_d = I_ONE;
        j_d = '0;
        t_d = T_W'(1);
      end
    end else if (adv) begin
      if (run_uw) begin
        t_d = t_q - T_W'(1);
        if (i_q == I_ONE) begin
          i_d = n_lim;
          j_d = j_q - J_W'(1);
        end else begin
          i_d = i_q - I_ONE;
        end
      end else begin
        t_d = t_q + T_W'(1);
        if (i_q == n_lim) begin
          i_d = I_ONE;
          j_d = j_q + J_W'(1);
        end else begin
          i_d = i_q + I_ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_q <= '0;
      j_q <= '0;
      t_q <= '0;
    end else if (ctr_en) begin
      i_q <= i_d;
      j_q <= j_d;
      t_q <= t_d;
    end
  end
endmodule

// File: rtl/kw_ctrl.sv
module kw_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic cph_ready,
  input  logic last,
  output logic mem_rd,
  output logic cap,
  output logic cph_start,
  output logic wb,
  output logic adv,
  output logic fin,
  output logic busy
);
  import kw_pkg::*;

  kw_state_e st_q;
  kw_state_e st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (go) st_d = ST_RD;
      ST_RD:   st_d = ST_LAT;
      ST_LAT:  st_d = ST_REQ;
      ST_REQ:  st_d = ST_WAIT;
      ST_WAIT: if (cph_ready) st_d = last ? ST_IDLE : ST_RD;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign busy      = (st_q != ST_IDLE);
  assign mem_rd    = (st_q == ST_RD);
  assign cap       = (st_q == ST_LAT);
  assign cph_start = (st_q == ST_REQ);
  assign wb        = (st_q == ST_WAIT) && cph_ready;
  assign adv       = wb && !last;
  assign fin       = wb && last;
endmodule

// File: rtl/kw_round_seq.sv
module kw_round_seq #(
  parameter int BLK_W    = 64,
  parameter int MAX_BLKS = 512,
  parameter int KEY_W    = 256
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  input  logic                              unwrap,
  input  logic [$clog2(MAX_BLKS+1)-1:0]     blk_cnt,
  input  logic [KEY_W-1:0]                  key,
  input  logic                              key_wide,
  input  logic                              a_load,
  input  logic [BLK_W-1:0]                  a_load_val,
  output logic [BLK_W-1:0]                  a_val,
  output logic                              busy,
  output logic                              done,
  output logic                              mem_rd,
  output logic                              mem_we,
  output logic [$clog2(MAX_BLKS)-1:0]       mem_addr,
  output logic [BLK_W-1:0]                  mem_wdata,
  input  logic [BLK_W-1:0]                  mem_rdata,
  output logic                              cph_start,
  output logic                              cph_decrypt,
  output logic                              cph_key_wide,
  output logic [KEY_W-1:0]                  cph_key,
  output logic [2*BLK_W-1:0]                cph_din,
  input  logic                              cph_ready,
  input  logic [2*BLK_W-1:0]                cph_dout
);
  import kw_pkg::*;

  localparam int CNT_W = $clog2(MAX_BLKS + 1);
  localparam int IDX_W = $clog2(MAX_BLKS);
  localparam int T_W   = $clog2(KW_PASSES * MAX_BLKS + 1);
  localparam int J_W   = $clog2(KW_PASSES);

  logic [CNT_W-1:0] n_q;
  logic             uw_q;
  logic             wide_q;
  logic [KEY_W-1:0] key_q;
  logic [BLK_W-1:0] a_q;
  logic [BLK_W-1:0] a_d;
  logic [BLK_W-1:0] blk_q;
  logic             done_q;
  logic             done_d;

  logic             go;
  logic             cap;
  logic             wb;
  logic             adv;
  logic             fin;
  logic             len_ok;
  logic             a_en;
  logic [CNT_W-1:0] i_q;
  logic [J_W-1:0]   j_q;
  logic [T_W-1:0]   t_q;
  logic             last;
  logic [BLK_W-1:0] t_ext;
  logic [BLK_W-1:0] a_in;

  assign len_ok = (blk_cnt != '0) && (blk_cnt <= CNT_W'(MAX_BLKS));
  assign go     = start && !busy && len_ok;

  kw_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .cph_ready (cph_ready),
    .last      (last),
    .mem_rd    (mem_rd),
    .cap       (cap),
    .cph_start (cph_start),
    .wb        (wb),
    .adv       (adv),
    .fin       (fin),
    .busy      (busy)
  );

  kw_step_ctr #(
    .CNT_W (CNT_W),
    .T_W   (T_W),
    .J_W   (J_W)
  ) u_step (
    .clk     (clk),
    .rst_n   (rst_n),
    .init    (go),
    .adv     (adv),
    .init_uw (unwrap),
    .run_uw  (uw_q),
    .n_init  (blk_cnt),
    .n_lim   (n_q),
    .i_q     (i_q),
    .j_q     (j_q),
    .t_q     (t_q),
    .last    (last)
  );

  // job configuration, captured once per accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q    <= '0;
      uw_q   <= 1'b0;
      wide_q <= 1'b0;
      key_q  <= '0;
    end else if (go) begin
      n_q    <= blk_cnt;
      uw_q   <= unwrap;
      wide_q <= key_wide;
      key_q  <= key;
    end
  end

  // block fetched from memory, held for the request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   blk_q <= '0;
    else if (cap) blk_q <= mem_rdata;
  end

  assign t_ext = BLK_W'(t_q);
  assign a_in  = uw_q ? (a_q ^ t_ext) : a_q;

  // integrity register: software load when idle, step result when busy
  assign a_en = (a_load && !busy) || wb;

  always_comb begin
    if (wb) a_d = uw_q ? cph_dout[2*BLK_W-1:BLK_W]
                       : (cph_dout[2*BLK_W-1:BLK_W] ^ t_ext);
    else    a_d = a_load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    a_q <= '0;
    else if (a_en) a_q <= a_d;
  end

  always_comb begin
    done_d = done_q;
    if (go)       done_d = 1'b0;
    else if (fin) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign a_val        = a_q;
  assign done         = done_q;
  assign mem_we       = wb;
  assign mem_addr     = IDX_W'(i_q - CNT_W'(1));
  assign mem_wdata    = cph_dout[BLK_W-1:0];
  assign cph_decrypt  = uw_q;
  assign cph_key_wide = wide_q;
  assign cph_key      = key_q;
  assign cph_din      = {a_in, blk_q};
endmodule

// File: rtl/kw_round_seq_chk.sv
module kw_round_seq_chk #(
  parameter int CNT_W = 10,
  parameter int IDX_W = 9,
  parameter int T_W   = 12,
  parameter int J_W   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] blk_cnt,
  input logic             cph_start,
  input logic             cph_ready,
  input logic             mem_rd,
  input logic             mem_we,
  input logic [IDX_W-1:0] mem_addr,
  input logic [CNT_W-1:0] n_q,
  input logic [T_W-1:0]   t_q,
  input logic [J_W-1:0]   j_q
);
  logic           outst;
  logic [T_W-1:0] six_n;

  assign six_n = T_W'(n_q) * T_W'(6);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         outst <= 1'b0;
    else if (cph_start) outst <= 1'b1;
    else if (cph_ready) outst <= 1'b0;
  end

  // R5
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cph_start |-> !outst);

  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cph_start |=> !cph_start);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R11
  wb_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (cph_ready && outst));

  // R11
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_we) |-> ({1'b0, mem_addr} < n_q));

  // R6
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (blk_cnt == '0)) |=> (!busy && $stable(done)));

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> $stable(n_q));

  // R2
  t_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((t_q != '0) && (t_q <= six_n)));

  // R1
  pass_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (j_q <= J_W'(5)));
endmodule

bind kw_round_seq kw_round_seq_chk #(
  .CNT_W (CNT_W),
  .IDX_W (IDX_W),
  .T_W   (T_W),
  .J_W   (J_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .blk_cnt   (blk_cnt),
  .cph_start (cph_start),
  .cph_ready (cph_ready),
  .mem_rd    (mem_rd),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .n_q       (n_q),
  .t_q       (t_q),
  .j_q       (j_q)
);

// File: tb/kw_round_seq_tb.sv
module kw_round_seq_tb;
  logic          clk;
  logic          rst_n;
  logic          start_tb;
  logic          start_evt;
  logic          unwrap;
  logic [9:0]    blk_cnt;
  logic [255:0]  key;
  logic          key_wide;
  logic          a_load;
  logic [63:0]   a_load_val;
  logic [63:0]   a_val;
  logic          busy;
  logic          done;
  logic          mem_rd;
  logic          mem_we;
  logic [8:0]    mem_addr;
  logic [63:0]   mem_wdata;
  logic [63:0]   mem_rdata;
  logic          cph_start;
  logic          cph_decrypt;
  logic          cph_key_wide;
  logic [255:0]  cph_key;
  logic [127:0]  cph_din;
  logic          cph_ready;
  logic [127:0]  cph_dout;

  logic [63:0]   mem_m [0:511];
  logic [63:0]   exp_r [0:511];
  logic [63:0]   sav_r [0:511];
  logic [63:0]   exp_a;
  logic [63:0]   sav_a;
  logic [255:0]  cur_key;
  logic          cur_wide;
  logic          cur_uw;
  logic          pend;
  logic [127:0]  res;
  int            dly;
  int            req_cnt;
  int            last_req;
  bit            evt_en;
  int            key_bad;
  int            n_chk;
  int            n_err;
  int            seed_dummy;

  kw_round_seq u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start_tb | start_evt),
    .unwrap       (unwrap),
    .blk_cnt      (blk_cnt),
    .key          (key),
    .key_wide     (key_wide),
    .a_load       (a_load),
    .a_load_val   (a_load_val),
    .a_val        (a_val),
    .busy         (busy),
    .done         (done),
    .mem_rd       (mem_rd),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_rdata    (mem_rdata),
    .cph_start    (cph_start),
    .cph_decrypt  (cph_decrypt),
    .cph_key_wide (cph_key_wide),
    .cph_key      (cph_key),
    .cph_din      (cph_din),
    .cph_ready    (cph_ready),
    .cph_dout     (cph_dout)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [127:0] kmix(input logic [255:0] k, input logic w);
    return k[127:0] ^ (w ? k[255:128] : 128'd0);
  endfunction

  function automatic logic [127:0] enc(input logic [127:0] x, input logic [255:0] k, input logic w);
    return {x[114:0], x[127:115]} ^ kmix(k, w);
  endfunction

  function automatic logic [127:0] dec(input logic [127:0] y, input logic [255:0] k, input logic w);
    logic [127:0] z;
    z = y ^ kmix(k, w);
    return {z[12:0], z[127:13]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic model(input logic uw, input int n, input logic [255:0] k, input logic w);
    logic [127:0] b;
    if (!uw) begin
      for (int j = 0; j < 6; j++)
        for (int i = 1; i <= n; i++) begin
          b = enc({exp_a, exp_r[i-1]}, k, w);
          exp_a = b[127:64] ^ 64'(n * j + i);
          exp_r[i-1] = b[63:0];
        end
    end else begin
      for (int j = 5; j >= 0; j--)
        for (int i = n; i >= 1; i--) begin
          b = dec({exp_a ^ 64'(n * j + i), exp_r[i-1]}, k, w);
          exp_a = b[127:64];
          exp_r[i-1] = b[63:0];
        end
    end
  endtask

  // block memory with one-cycle read latency
  always @(posedge clk) begin
    if (mem_we) mem_m[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem_m[mem_addr];
  end

  // reversible cipher stand-in with a random answer delay
  always @(negedge clk) begin
    cph_ready = 1'b0;
    start_evt = 1'b0;
    if (pend) begin
      if (dly == 0) begin
        cph_ready = 1'b1;
        cph_dout  = res;
        pend      = 1'b0;
        req_cnt++;
        if (evt_en && req_cnt == last_req) start_evt = 1'b1;
      end else begin
        dly--;
      end
    end
    if (cph_start) begin
      if (pend) begin
        n_err++;
        $display("FAIL R5 actual=second request expected=none outstanding");
      end
      if (cph_key_wide != cur_wide || cph_key[127:0] != cur_key[127:0] ||
          (cur_wide && cph_key != cur_key) || cph_decrypt != cur_uw)
        key_bad++;
      res  = cph_decrypt ? dec(cph_din, cph_key, cph_key_wide)
                         : enc(cph_din, cph_key, cph_key_wide);
      pend = 1'b1;
      dly  = int'($urandom % 3);
    end
  end

  task automatic fill(input int n);
    for (int k = 0; k < n; k++) mem_m[k] = {$urandom, $urandom};
  endtask

  // mode: 0 plain, 1 disturb while busy, 2 start on last ready
  task automatic run_op(input logic uw, input int n, input logic [255:0] k,
                        input logic w, input logic [63:0] a0, input int mode);
    int cyc;
    int bad;
    int first;
    for (int q = 0; q < n; q++) exp_r[q] = mem_m[q];
    exp_a = a0;
    model(uw, n, k, w);
    @(negedge clk);
    blk_cnt = 10'(n); key = k; key_wide = w; unwrap = uw;
    a_load = 1'b1; a_load_val = a0;
    cur_key = k; cur_wide = w; cur_uw = uw; key_bad = 0;
    @(negedge clk);
    a_load = 1'b0;
    chk(a_val == a0, "R9 idle load", 128'(a_val), 128'(a0));
    req_cnt = 0; last_req = 6 * n; evt_en = (mode == 2);
    start_tb = 1'b1;
    @(negedge clk);
    start_tb = 1'b0;
    chk(busy && !done, "R8 done cleared on start", {busy, done}, 2'b10);
    if (mode == 1) begin
      repeat (7) @(negedge clk);
      start_tb = 1'b1; blk_cnt = 10'd3; unwrap = ~uw; key = ~k;
      a_load = 1'b1; a_load_val = ~a0;
      @(negedge clk);
      start_tb = 1'b0; a_load = 1'b0;
      chk(busy, "R7 still busy", 128'(busy), 128'd1);
    end
    cyc = 0;
    while (!done && cyc < 40000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done && !busy, "R8 done after last step", {done, busy}, 2'b10);
    chk(req_cnt == 6 * n, "R1 request count", 128'(req_cnt), 128'(6 * n));
    chk(key_bad == 0, "R4 key and mode to cipher", 128'(key_bad), 128'd0);
    chk(a_val == exp_a, uw ? "R3 final A" : "R2 final A", 128'(a_val), 128'(exp_a));
    bad = 0; first = 0;
    for (int q = 0; q < n; q++)
      if (mem_m[q] != exp_r[q]) begin
        if (bad == 0) first = q;
        bad++;
      end
    chk(bad == 0, uw ? "R3 blocks (R11 addr)" : "R2 blocks (R11 addr)",
        128'(mem_m[first]), 128'(exp_r[first]));
    if (mode == 2) begin
      @(negedge clk);
      chk(!busy && done, "R7 start at final ready ignored", {busy, done}, 2'b01);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [255:0] k;
    logic [63:0]  a0;
    int           n;
    logic         uw;
    n_chk = 0; n_err = 0;
    seed_dummy = int'($urandom(32'd4711));
    rst_n = 1'b0; start_tb = 1'b0; start_evt = 1'b0; unwrap = 1'b0;
    blk_cnt = '0; key = '0; key_wide = 1'b0; a_load = 1'b0; a_load_val = '0;
    cph_ready = 1'b0; cph_dout = '0; pend = 1'b0; dly = 0;
    req_cnt = 0; last_req = 0; evt_en = 1'b0; key_bad = 0;
    cur_key = '0; cur_wide = 1'b0; cur_uw = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !cph_start && !mem_rd && !mem_we, "R10 reset state",
        {busy, done, cph_start, mem_rd, mem_we}, 5'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R10 idle after release", {busy, done}, 2'b00);

    // smallest object, 128-bit key
    fill(1);
    k = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    run_op(1'b0, 1, k, 1'b0, 64'hA6A6A6A6A6A6A6A6, 0);

    // wrap then unwrap round trip, 256-bit key
    fill(3);
    for (int q = 0; q < 3; q++) sav_r[q] = mem_m[q];
    sav_a = 64'hA6A6A6A6A6A6A6A6;
    k = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    run_op(1'b0, 3, k, 1'b1, sav_a, 0);
    run_op(1'b1, 3, k, 1'b1, a_val, 0);
    chk(a_val == sav_a, "R3 round trip A", 128'(a_val), 128'(sav_a));
    chk(mem_m[0] == sav_r[0] && mem_m[2] == sav_r[2], "R3 round trip blocks",
        {mem_m[0], mem_m[2]}, {sav_r[0], sav_r[2]});

    // zero and oversize counts are ignored
    a0 = a_val;
    @(negedge clk);
    blk_cnt = 10'd0; start_tb = 1'b1;
    @(negedge clk);
    start_tb = 1'b0;
    chk(!busy && done && a_val == a0, "R6 zero count ignored", {busy, done}, 2'b01);
    blk_cnt = 10'd600; start_tb = 1'b1;
    @(negedge clk);
    start_tb = 1'b0;
    chk(!busy && done, "R6 oversize count ignored", {busy, done}, 2'b01);

    // start and A load while busy are ignored
    fill(4);
    k = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    run_op(1'b0, 4, k, 1'b0, {$urandom, $urandom}, 1);
    chk(a_val == exp_a, "R9 load while busy ignored", 128'(a_val), 128'(exp_a));

    // start coinciding with the last cipher answer
    fill(2);
    run_op(1'b1, 2, k, 1'b1, {$urandom, $urandom}, 2);

    // random jobs
    for (int r = 0; r < 6; r++) begin
      n  = 1 + int'($urandom % 24);
      uw = 1'($urandom);
      fill(n);
      k = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      run_op(uw, n, k, 1'($urandom), {$urandom, $urandom}, 0);
    end

    // largest object
    fill(512);
    k = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    run_op(1'b0, 512, k, 1'b1, 64'hA6A6A6A6A6A6A6A6, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule